// File: doc/BRIEF.md
# Double-Buffered Quarter-Resolution Raster Framebuffer Controller

This block generates a VGA-style raster and feeds it from one of two external asynchronous byte-wide SRAMs. Each SRAM has its own address, data and control bus. At any moment one SRAM is the shown page and the other is the drawing page. Display reads and host writes therefore never compete for a bus. Each displayed pixel is read from the shown page at an address formed by dropping the two low bits of the horizontal and vertical raster positions. This gives a 160x120 image of 8-bit pixels, each repeated over a 4x4 block of screen pixels. The stored byte is split 3-3-2 into red, green and blue, and each channel is widened to a 4-bit DAC code.

A slow host places a pixel by loading a column register, then a row register, then a data register, each through a separate write operation. Loading the data register fires a single-cycle write strobe into the drawing page at the latched column and row. When the host has finished a frame, it raises a swap request. The request is held pending until the raster enters vertical blanking. The two SRAMs then trade roles, so a frame is never shown half old and half new.

The pixel rate is half the input clock, produced by a toggle register that acts as a clock enable. All raster timing values are parameters.

Top module: `fbPageFlip`

## Requirements
- R1: The raster advances one pixel every second input clock. The sync and colour outputs change only on those pixel edges.
- R2: `hsyncN` is low for exactly H_SYNC pixels, starting H_FP pixels after the last visible pixel of each line, and high otherwise.
- R3: `vsyncN` is low for exactly V_SYNC lines, starting V_FP lines after the last visible line, and high otherwise.
- R4: The colour outputs are zero for every pixel outside the H_VIS x V_VIS visible area.
- R5: A visible pixel at column h, row v shows the shown-page byte at the 15-bit address {v>>2 (7 bits), h>>2 (8 bits)}, with bits 14:8 holding the row and 7:0 the column. Address bits 16:15 are always zero.
- R6: Pixel byte p drives red = {p[7:5],p[7]}, green = {p[4:2],p[4]} and blue = {p[1:0],p[1:0]}.
- R7: With `hostWr` high, `hostSel` 0 loads the column from hostData[7:0], 1 loads the row from hostData[6:0], and 2 loads the data byte. Loading data drives exactly one clock of write-enable low on the drawing SRAM, at address {row, column} with the data byte.
- R8: The shown SRAM has output enable low and write enable high at all times. The drawing SRAM has output enable high.
- R9: A swap request is held and takes effect on the clock edge where the raster moves from the last visible line into the first blanking line. The shown page changes there and at no other point. Several requests before that edge cause a single exchange.
- R10: After reset, SRAM A is the shown page, both syncs are high, the colour outputs are zero and both write enables are high.
- R11: `hostSel` 3 loads nothing and writes nothing. The column and row registers keep their values across data writes, so repeated data loads reuse the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, twice the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host register-load strobe |
| hostSel | input | 2 | Target register: 0 column, 1 row, 2 data, 3 none |
| hostData | input | 8 | Host load value |
| hostSwap | input | 1 | Page exchange request pulse |
| memAAddr | output | 17 | SRAM A address |
| memAWdata | output | 8 | SRAM A write data |
| memARdata | input | 8 | SRAM A read data |
| memAWeN | output | 1 | SRAM A write enable, active low |
| memAOeN | output | 1 | SRAM A output enable, active low |
| memBAddr | output | 17 | SRAM B address |
| memBWdata | output | 8 | SRAM B write data |
| memBRdata | input | 8 | SRAM B read data |
| memBWeN | output | 1 | SRAM B write enable, active low |
| memBOeN | output | 1 | SRAM B output enable, active low |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| red | output | 4 | Red DAC code |
| green | output | 4 | Green DAC code |
| blue | output | 4 | Blue DAC code |

## Verification
The single-cycle write-strobe property relies on the host leaving at least one idle clock between two data loads. The bench's load task keeps `hostWr` high for exactly one clock and then drops it. The properties also assume that read data settles within one clock of an address change. The bench's behavioural SRAM arrays return the addressed byte combinationally. No data load is issued while a swap is pending, because a write in flight at the blanking edge defers the exchange by one frame, and the bench's page model does not cover that case.

// File: rtl/fbPkg.sv
package fbPkg;

  typedef enum logic [1:0] {
    SEL_COL  = 2'd0,
    SEL_ROW  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } hostSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pixEn;
    logic visible;
    logic hsyncOn;
    logic vsyncOn;
    logic loadCol;
    logic loadRow;
    logic loadData;
    logic swapNow;
  } fbStrobe_t;

  // 3-3-2 byte to three 4-bit DAC codes by top-bit replication
  function automatic logic [11:0] pixToRgb(input logic [7:0] p);
    logic [3:0] r, g, b;
    r = {p[7:5], p[7]};
    g = {p[4:2], p[4]};
    b = {p[1:0], p[1:0]};
    return {r, g, b};
  endfunction

endpackage

// File: rtl/fbCtrl.sv
module fbCtrl
  import fbPkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int X_BITS = 8,
  parameter int Y_BITS = 7,
  parameter int BIN_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [1:0]        hostSel,
  input  logic              hostSwap,
  input  logic              wrBusy,
  output fbStrobe_t         stb,
  output logic [X_BITS-1:0] xBin,
  output logic [Y_BITS-1:0] yBin
);

  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int HS_LO = H_VIS + H_FP;
  localparam int HS_HI = HS_LO + H_SYNC;
  localparam int VS_LO = V_VIS + V_FP;
  localparam int VS_HI = VS_LO + V_SYNC;

  logic          pixTgl;
  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic          swapPend;
  logic          lineEnd, frameEnd, blankEdge, swapNow;

  assign lineEnd   = (hCnt == HW'(H_TOT - 1));
  assign frameEnd  = (vCnt == VW'(V_TOT - 1));
  assign blankEdge = pixTgl & lineEnd & (vCnt == VW'(V_VIS - 1));
  // a write strobe still on the bus defers the exchange to the next frame
  assign swapNow   = blankEdge & swapPend & ~wrBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixTgl   <= 1'b0;
      hCnt     <= '0;
      vCnt     <= '0;
      swapPend <= 1'b0;
    end else begin
      pixTgl   <= ~pixTgl;
      swapPend <= (swapPend | hostSwap) & ~swapNow;
      if (pixTgl) begin
        if (lineEnd) begin
          hCnt <= '0;
          vCnt <= frameEnd ? '0 : vCnt + 1'b1;
        end else begin
          hCnt <= hCnt + 1'b1;
        end
      end
    end
  end

  assign stb.pixEn    = pixTgl;
  assign stb.visible  = (hCnt < HW'(H_VIS)) && (vCnt < VW'(V_VIS));
  assign stb.hsyncOn  = (hCnt >= HW'(HS_LO)) && (hCnt < HW'(HS_HI));
  assign stb.vsyncOn  = (vCnt >= VW'(VS_LO)) && (vCnt < VW'(VS_HI));
  assign stb.loadCol  = hostWr && (hostSel == SEL_COL);
  assign stb.loadRow  = hostWr && (hostSel == SEL_ROW);
  assign stb.loadData = hostWr && (hostSel == SEL_DATA);
  assign stb.swapNow  = swapNow;

  assign xBin = X_BITS'(hCnt >> BIN_SHIFT);
  assign yBin = Y_BITS'(vCnt >> BIN_SHIFT);

endmodule

// File: rtl/fbData.sv
module fbData
  import fbPkg::*;
#(
  parameter int X_BITS = 8,
  parameter int Y_BITS = 7,
  parameter int ADDR_W = 17,
  parameter int PIX_W  = 8,
  parameter int DAC_W  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fbStrobe_t                     stb,
  input  logic [X_BITS-1:0]             xBin,
  input  logic [Y_BITS-1:0]             yBin,
  input  logic [PIX_W-1:0]              hostData,
  input  logic [1:0][PIX_W-1:0]         busRdata,
  output logic [1:0][ADDR_W-1:0]        busAddr,
  output logic [1:0][PIX_W-1:0]         busWdata,
  output logic [1:0]                    busWeN,
  output logic [1:0]                    busOeN,
  output logic                          wrBusy,
  output logic                          hsyncN,
  output logic                          vsyncN,
  output logic [3*DAC_W-1:0]            rgb
);

  logic [X_BITS-1:0] colLat;
  logic [Y_BITS-1:0] rowLat;
  logic [PIX_W-1:0]  dataLat;
  logic              wrPend;
  logic              page;      // index of the shown SRAM
  logic [ADDR_W-1:0] dispAddr, drawAddr;
  logic [PIX_W-1:0]  dispPix;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colLat  <= '0;
      rowLat  <= '0;
      dataLat <= '0;
      wrPend  <= 1'b0;
      page    <= 1'b0;
    end else begin
      if (stb.loadCol)  colLat  <= hostData[X_BITS-1:0];
      if (stb.loadRow)  rowLat  <= hostData[Y_BITS-1:0];
      if (stb.loadData) dataLat <= hostData;
      wrPend <= stb.loadData;
      page   <= page ^ stb.swapNow;
    end
  end

  assign wrBusy   = wrPend;
  assign dispAddr = ADDR_W'({yBin, xBin});
  assign drawAddr = ADDR_W'({rowLat, colLat});

  for (genvar g = 0; g < 2; g++) begin : gBus
    logic shown;
    assign shown       = (page == 1'(g));
    assign busAddr[g]  = shown ? dispAddr : drawAddr;
    assign busWdata[g] = dataLat;
    assign busWeN[g]   = shown | ~wrPend;
    assign busOeN[g]   = ~shown;
  end

  assign dispPix = busRdata[page];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncN <= 1'b1;
      vsyncN <= 1'b1;
      rgb    <= '0;
    end else if (stb.pixEn) begin
      hsyncN <= ~stb.hsyncOn;
      vsyncN <= ~stb.vsyncOn;
      rgb    <= stb.visible ? pixToRgb(dispPix) : '0;
    end
  end

endmodule

// File: rtl/fbPageFlip.sv
module fbPageFlip
  import fbPkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [1:0]        hostSel,
  input  logic [7:0]        hostData,
  input  logic              hostSwap,
  output logic [ADDR_W-1:0] memAAddr,
  output logic [7:0]        memAWdata,
  input  logic [7:0]        memARdata,
  output logic              memAWeN,
  output logic              memAOeN,
  output logic [ADDR_W-1:0] memBAddr,
  output logic [7:0]        memBWdata,
  input  logic [7:0]        memBRdata,
  output logic              memBWeN,
  output logic              memBOeN,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic [3:0]        red,
  output logic [3:0]        green,
  output logic [3:0]        blue
);

  localparam int X_BITS = 8;
  localparam int Y_BITS = 7;

  fbStrobe_t              stb;
  logic [X_BITS-1:0]      xBin;
  logic [Y_BITS-1:0]      yBin;
  logic                   wrBusy;
  logic [1:0][7:0]        busRdata, busWdata;
  logic [1:0][ADDR_W-1:0] busAddr;
  logic [1:0]             busWeN, busOeN;
  logic [11:0]            rgb;

  fbCtrl #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .X_BITS(X_BITS), .Y_BITS(Y_BITS), .BIN_SHIFT(2)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostSel(hostSel),
    .hostSwap(hostSwap), .wrBusy(wrBusy), .stb(stb),
    .xBin(xBin), .yBin(yBin)
  );

  fbData #(
    .X_BITS(X_BITS), .Y_BITS(Y_BITS), .ADDR_W(ADDR_W), .PIX_W(8), .DAC_W(4)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .xBin(xBin), .yBin(yBin),
    .hostData(hostData), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .busWeN(busWeN), .busOeN(busOeN),
    .wrBusy(wrBusy), .hsyncN(hsyncN), .vsyncN(vsyncN), .rgb(rgb)
  );

  assign busRdata[0] = memARdata;
  assign busRdata[1] = memBRdata;
  assign memAAddr    = busAddr[0];
  assign memBAddr    = busAddr[1];
  assign memAWdata   = busWdata[0];
  assign memBWdata   = busWdata[1];
  assign memAWeN     = busWeN[0];
  assign memBWeN     = busWeN[1];
  assign memAOeN     = busOeN[0];
  assign memBOeN     = busOeN[1];
  assign {red, green, blue} = rgb;

endmodule

// File: rtl/fbPageFlipChk.sv
module fbPageFlipChk (
  input logic       clk,
  input logic       rstN,
  input logic       memAWeN,
  input logic       memAOeN,
  input logic       memBWeN,
  input logic       memBOeN,
  input logic [1:0] addrAHi,
  input logic [1:0] addrBHi,
  input logic       hsyncN,
  input logic       vsyncN,
  input logic [3:0] red,
  input logic [3:0] green,
  input logic [3:0] blue
);

  AST_SHOWN_A_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memAOeN |-> memAWeN); // R8
  AST_SHOWN_B_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memBOeN |-> memBWeN); // R8
  AST_ONE_PAGE_SHOWN: assert property (@(posedge clk) disable iff (!rstN)
    memAOeN != memBOeN); // R8
  AST_WE_A_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !memAWeN |=> memAWeN); // R7
  AST_WE_B_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !memBWeN |=> memBWeN); // R7
  AST_ADDR_HI_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addrAHi == 2'b00) && (addrBHi == 2'b00)); // R5
  AST_BLANK_IN_HSYNC: assert property (@(posedge clk) disable iff (!rstN)
    !hsyncN |-> ({red, green, blue} == 12'h000)); // R4
  AST_HSYNC_PIX_RATE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hsyncN) |=> $stable(hsyncN)); // R1
  AST_VSYNC_PIX_RATE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vsyncN) |=> $stable(vsyncN)); // R1

endmodule

bind fbPageFlip fbPageFlipChk uChk (
  .clk(clk), .rstN(rstN),
  .memAWeN(memAWeN), .memAOeN(memAOeN),
  .memBWeN(memBWeN), .memBOeN(memBOeN),
  .addrAHi(memAAddr[ADDR_W-1:ADDR_W-2]), .addrBHi(memBAddr[ADDR_W-1:ADDR_W-2]),
  .hsyncN(hsyncN), .vsyncN(vsyncN),
  .red(red), .green(green), .blue(blue)
);

// File: tb/sim_fbPageFlip.sv
module sim_fbPageFlip;

  localparam int H_VIS = 32, H_FP = 4, H_SYNC = 6, H_BP = 6;
  localparam int V_VIS = 16, V_FP = 2, V_SYNC = 2, V_BP = 4;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0, hostSwap = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [7:0]  hostData = 8'd0;
  logic [16:0] memAAddr, memBAddr;
  logic [7:0]  memAWdata, memBWdata, memARdata, memBRdata;
  logic        memAWeN, memAOeN, memBWeN, memBOeN;
  logic        hsyncN, vsyncN;
  logic [3:0]  red, green, blue;

  logic [7:0] memA [0:32767];
  logic [7:0] memB [0:32767];

  int checks = 0, fails = 0;
  int weA = 0, weB = 0, litPix = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  // independent raster / page model
  bit   mPix, mPage, mSwapPend, flip;
  int   mH, mV;
  bit   expH, expV;
  logic [11:0] expRgb;

  always #5 clk = ~clk;

  assign memARdata = memA[memAAddr[14:0]];
  assign memBRdata = memB[memBAddr[14:0]];

  fbPageFlip #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostSel(hostSel),
    .hostData(hostData), .hostSwap(hostSwap),
    .memAAddr(memAAddr), .memAWdata(memAWdata), .memARdata(memARdata),
    .memAWeN(memAWeN), .memAOeN(memAOeN),
    .memBAddr(memBAddr), .memBWdata(memBWdata), .memBRdata(memBRdata),
    .memBWeN(memBWeN), .memBOeN(memBOeN),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .red(red), .green(green), .blue(blue)
  );

  function automatic logic [11:0] expand(input logic [7:0] p);
    return {p[7:5], p[7], p[4:2], p[4], p[1:0], p[1:0]};
  endfunction

  function automatic logic [14:0] binAddr(input int h, input int v);
    logic [6:0] y;
    logic [7:0] x;
    y = 7'(v / 4);
    x = 8'(h / 4);
    return {y, x};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPix <= 1'b0; mH <= 0; mV <= 0; mPage <= 1'b0; mSwapPend <= 1'b0;
      expH <= 1'b1; expV <= 1'b1; expRgb <= '0;
    end else begin
      flip = 1'b0;
      if (mPix) begin
        expH <= !(mH >= H_VIS + H_FP && mH < H_VIS + H_FP + H_SYNC);
        expV <= !(mV >= V_VIS + V_FP && mV < V_VIS + V_FP + V_SYNC);
        if (mH < H_VIS && mV < V_VIS)
          expRgb <= expand(mPage ? memB[binAddr(mH, mV)] : memA[binAddr(mH, mV)]);
        else
          expRgb <= '0;
        flip = (mH == H_TOT - 1) && (mV == V_VIS - 1) && mSwapPend;
        if (mH == H_TOT - 1) begin
          mH <= 0;
          mV <= (mV == V_TOT - 1) ? 0 : mV + 1;
        end else mH <= mH + 1;
      end
      mSwapPend <= (mSwapPend | hostSwap) & ~flip;
      mPage     <= mPage ^ flip;
      mPix      <= ~mPix;
    end
  end

  // behavioural SRAM writes and continuous output comparison
  always @(negedge clk) begin
    if (rstN && !memAWeN) begin
      memA[memAAddr[14:0]] = memAWdata;
      weA++;
      if (monOn) check(mPage == 1'b1, "R8 write only to drawing page A", mPage, 1);
    end
    if (rstN && !memBWeN) begin
      memB[memBAddr[14:0]] = memBWdata;
      weB++;
      if (monOn) check(mPage == 1'b0, "R8 write only to drawing page B", mPage, 0);
    end
    if (monOn) begin
      check(hsyncN == expH, "R2 hsync", hsyncN, expH);
      check(vsyncN == expV, "R3 vsync", vsyncN, expV);
      check({red, green, blue} == expRgb, "R4/R5/R6 colour", {red, green, blue}, expRgb);
      check(memAOeN == mPage && memBOeN == !mPage, "R9 shown page", memAOeN, mPage);
      if ({red, green, blue} != 12'h0) litPix++;
    end
  end

  task automatic hostOp(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostSel = sel; hostData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitLine(input int v);
    while (!(mV == v && mH == 2)) @(negedge clk);
  endtask

  task automatic tReset;
    check(hsyncN == 1'b1 && vsyncN == 1'b1, "R10 syncs high", {hsyncN, vsyncN}, 3);
    check({red, green, blue} == 12'h0, "R10 colour zero", {red, green, blue}, 0);
    check(memAOeN == 1'b0 && memBOeN == 1'b1, "R10 A shown", {memAOeN, memBOeN}, 1);
    check(memAWeN && memBWeN, "R10 no write", {memAWeN, memBWeN}, 3);
  endtask

  task automatic tWriteBasic;
    int a0, b0;
    a0 = weA; b0 = weB;
    hostOp(2'd0, 8'd3);
    hostOp(2'd1, 8'd1);
    hostOp(2'd2, 8'hA5);
    idle(2);
    check(memB[{7'd1, 8'd3}] == 8'hA5, "R7 pixel in drawing page", memB[{7'd1, 8'd3}], 8'hA5);
    check(weB == b0 + 1, "R7 single write strobe", weB - b0, 1);
    check(weA == a0, "R8 shown page untouched", weA - a0, 0);
    // full-row address corner
    hostOp(2'd0, 8'd159);
    hostOp(2'd1, 8'd119);
    hostOp(2'd2, 8'h3C);
    idle(2);
    check(memB[{7'd119, 8'd159}] == 8'h3C, "R7 far corner pixel", memB[{7'd119, 8'd159}], 8'h3C);
  endtask

  task automatic tLatchHold;
    int b0;
    b0 = weB;
    hostOp(2'd0, 8'd6);
    hostOp(2'd1, 8'd2);
    hostOp(2'd2, 8'h11);
    hostOp(2'd2, 8'hE7);
    idle(2);
    check(memB[{7'd2, 8'd6}] == 8'hE7, "R11 latches held across data", memB[{7'd2, 8'd6}], 8'hE7);
    check(weB == b0 + 2, "R7 one strobe per data load", weB - b0, 2);
  endtask

  task automatic tIgnoredSel;
    int b0;
    b0 = weB;
    hostOp(2'd0, 8'd5);
    hostOp(2'd1, 8'd3);
    hostOp(2'd3, 8'd7);
    idle(2);
    check(weB == b0, "R11 sel 3 writes nothing", weB - b0, 0);
    hostOp(2'd2, 8'h99);
    idle(2);
    check(memB[{7'd3, 8'd5}] == 8'h99, "R11 sel 3 left column", memB[{7'd3, 8'd5}], 8'h99);
    check(memB[{7'd3, 8'd7}] != 8'h99, "R11 no write at ignored value", memB[{7'd3, 8'd7}], 0);
  endtask

  task automatic tSwap;
    waitLine(3);
    @(negedge clk); hostSwap = 1'b1;
    @(negedge clk); hostSwap = 1'b0;
    waitLine(V_VIS - 1);
    check(memAOeN == 1'b0, "R9 no swap before blanking", memAOeN, 0);
    @(negedge vsyncN); @(negedge clk);
    check(memBOeN == 1'b0 && memAOeN == 1'b1, "R9 swap at blanking", {memAOeN, memBOeN}, 2);
  endtask

  task automatic tDoubleSwap;
    waitLine(2);
    @(negedge clk); hostSwap = 1'b1;
    @(negedge clk); hostSwap = 1'b0;
    idle(10);
    @(negedge clk); hostSwap = 1'b1;
    @(negedge clk); hostSwap = 1'b0;
    @(negedge vsyncN); @(negedge clk);
    check(memAOeN == 1'b0, "R9 two requests one exchange", memAOeN, 0);
    idle(2 * H_TOT * V_TOT);
    check(memAOeN == 1'b0, "R9 no later exchange", memAOeN, 0);
  endtask

  task automatic tWriteToA;
    int a0, b0;
    a0 = weA; b0 = weB;
    hostOp(2'd0, 8'd1);
    hostOp(2'd1, 8'd0);
    hostOp(2'd2, 8'h5A);
    idle(2);
    check(memA[{7'd0, 8'd1}] == 8'h5A, "R7 write follows drawing page A", memA[{7'd0, 8'd1}], 8'h5A);
    check(weB == b0 && weA == a0 + 1, "R8 shown B untouched", weB - b0, 0);
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) begin
      memA[i] = 8'(i * 37 + 5);
      memB[i] = 8'(i * 11 + 200);
    end
    idle(3);
    tReset;
    @(negedge clk); rstN = 1'b1;
    monOn = 1'b1;
    idle(40);
    tWriteBasic;
    tLatchHold;
    tIgnoredSel;
    tSwap;
    idle(2 * H_TOT * V_TOT);
    tWriteToA;
    tDoubleSwap;
    check(litPix > 0, "R5 visible pixels lit", litPix, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule